// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

A watchdog peripheral with two clock domains. Software reaches four 32-bit word registers through a plain write/read bus on the bus clock. The count itself runs on a separate oscillator clock. Software stores a 12-bit period value `N`, clears the elapsed count, and sets the enable bit. One period lasts `(N+1) * 2^PRESCALE_W` oscillator cycles. With the default `PRESCALE_W = 20` this is `(N+1)` times 2^20 cycles.

The first period that ends without a refresh raises the interrupt. The next one, again without a refresh, raises the reset request. A refresh write clears the count and the interrupt. Configuration writes cross into the oscillator domain through a toggle handshake, and a busy bit covers that crossing. The refresh command crosses on its own path with no busy window.

The oscillator-side controller has four states:
- `ST_IDLE`: not enabled, count held at zero.
- `ST_RUN`: counting, interrupt low.
- `ST_WARN`: one period has ended, interrupt high.
- `ST_TRIP`: reset request high.

It has these transitions:
- IDLE→RUN when the enable arrives.
- RUN→WARN on the end of a period.
- WARN→RUN on a refresh.
- WARN→TRIP on the end of the second period.
- TRIP stays in TRIP until module reset.

A refresh in RUN keeps RUN and clears the count. A refresh that lands in the same cycle as the end of a period wins.

Top module: `wdt2_top`

## Requirements
- R1: After module reset every register reads zero, and `irq_o` and `rst_req_o` are low.
- R2: The period word (byte offset 0x04) keeps only bits 31:20 of a write. Bits 19:0 read back as zero.
- R3: The enable is bit 0 of the control word (offset 0x00). Writing 1 sets it. A later write of 0 leaves it at 1.
- R4: Control bit 1 (busy) reads 1 from the cycle after an accepted write to offset 0x00, 0x04 or 0x08 until that write has crossed into the oscillator domain. Writes to those three offsets while busy change nothing.
- R5: About `(N+1)*2^PRESCALE_W` oscillator cycles after the enable takes effect, with no refresh, `irq_o` rises. Bit 0 of the word at offset 0x0C then reads 1.
- R6: Writing a value with bit 0 = 1 to offset 0x0C clears the count and the interrupt. The next interrupt comes a full period after the refresh.
- R7: A second period ending without a refresh raises `rst_req_o`. It stays high through later refresh writes, and `irq_o` drops when it rises.
- R8: Any write to offset 0x08 restarts the count from zero once it has crossed. That offset reads as zero.
- R9: A write to offset 0x0C with bit 0 = 0 has no effect on the count or the interrupt.
- R10: Module reset returns the block from any state, including trip, to the R1 state with the enable cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| osc_clk_i | input | 1 | Oscillator clock driving the count |
| rst_ni | input | 1 | Asynchronous active-low module reset for both domains |
| wr_en_i | input | 1 | Write strobe, one bus cycle per write |
| addr_i | input | ADDR_W | Byte offset; bits 3:2 select the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt level, oscillator domain |
| rst_req_o | output | 1 | Reset request level, oscillator domain |

## Verification
The assertions assume the following:
- The reset is released in a way both clocks see as clean.
- Software sends no further configuration write while busy reads 1.
- Refresh writes are spaced well beyond a few oscillator cycles. Two refresh toggles inside one synchronizer window cancel out.

The bench waits for busy to fall after every configuration write. It spaces refreshes by many oscillator periods. It places every timing check at least six oscillator cycles away from the expected edge, so the few cycles of crossing latency cannot move a result across a sampling point.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    localparam int DATA_W   = 32;
    localparam int PERIOD_W = 12;

    // word index taken from address bits 3:2
    localparam logic [1:0] WI_CTRL    = 2'd0;
    localparam logic [1:0] WI_PERIOD  = 2'd1;
    localparam logic [1:0] WI_ELAPSED = 2'd2;
    localparam logic [1:0] WI_REFRESH = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WARN = 2'd2,
        ST_TRIP = 2'd3
    } wdt_state_e;
endpackage

// File: rtl/wdt2_sync.sv
module wdt2_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    input  logic                irq_sync_i,
    input  logic                ack_sync_i,
    output logic                req_tgl_o,
    output logic                ref_tgl_o,
    output logic                cfg_en_o,
    output logic                cfg_clr_o,
    output logic [PERIOD_W-1:0] cfg_period_o
);
    localparam int LOW_W = DATA_W - PERIOD_W;

    logic [1:0]          word;
    logic                busy;
    logic                cfg_wr;
    logic                en_q;
    logic                clr_q;
    logic                req_q;
    logic                ref_q;
    logic [PERIOD_W-1:0] period_q;

    assign word   = addr_i[3:2];
    assign busy   = req_q ^ ack_sync_i;
    assign cfg_wr = wr_en_i && !busy && (word != WI_REFRESH);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q     <= 1'b0;
            clr_q    <= 1'b0;
            req_q    <= 1'b0;
            ref_q    <= 1'b0;
            period_q <= '0;
        end else begin
            if (cfg_wr) begin
                req_q <= ~req_q;
                clr_q <= (word == WI_ELAPSED);
                if (word == WI_CTRL && wdata_i[0]) begin
                    en_q <= 1'b1;
                end
                if (word == WI_PERIOD) begin
                    period_q <= wdata_i[DATA_W-1 -: PERIOD_W];
                end
            end
            if (wr_en_i && word == WI_REFRESH && wdata_i[0]) begin
                ref_q <= ~ref_q;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (word)
            WI_CTRL:    rdata_o[1:0] = {busy, en_q};
            WI_PERIOD:  rdata_o = {period_q, {LOW_W{1'b0}}};
            WI_ELAPSED: rdata_o = '0;
            WI_REFRESH: rdata_o[0] = irq_sync_i;
            default:    rdata_o = '0;
        endcase
    end

    assign req_tgl_o    = req_q;
    assign ref_tgl_o    = ref_q;
    assign cfg_en_o     = en_q;
    assign cfg_clr_o    = clr_q;
    assign cfg_period_o = period_q;

    assert_busy_blocks_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && busy && word == WI_PERIOD) |=> $stable(period_q));

    assert_enable_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_q |=> en_q);
endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
    import wdt2_pkg::*;
#(
    parameter int PRESCALE_W = 20
) (
    input  logic                osc_clk_i,
    input  logic                rst_ni,
    input  logic                req_sync_i,
    input  logic                ref_sync_i,
    input  logic                cfg_en_i,
    input  logic                cfg_clr_i,
    input  logic [PERIOD_W-1:0] cfg_period_i,
    output logic                ack_tgl_o,
    output logic                irq_o,
    output logic                rst_req_o
);
    localparam int CNT_W = PERIOD_W + PRESCALE_W;

    wdt_state_e          state_q, state_d;
    logic                req_prev_q;
    logic                ref_prev_q;
    logic                en_q;
    logic [PERIOD_W-1:0] period_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [CNT_W-1:0]    term;
    logic                apply;
    logic                ref_pulse;
    logic                ovf;
    logic                counting;
    logic                irq_q;
    logic                rst_req_q;

    assign apply     = req_sync_i ^ req_prev_q;
    assign ref_pulse = ref_sync_i ^ ref_prev_q;
    assign term      = {period_q, {PRESCALE_W{1'b1}}};
    assign counting  = (state_q == ST_RUN) || (state_q == ST_WARN);
    assign ovf       = counting && (cnt_q >= term);

    // configuration capture and counter
    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_prev_q <= 1'b0;
            ref_prev_q <= 1'b0;
            en_q       <= 1'b0;
            period_q   <= '0;
            cnt_q      <= '0;
        end else begin
            req_prev_q <= req_sync_i;
            ref_prev_q <= ref_sync_i;
            if (apply) begin
                en_q     <= cfg_en_i;
                period_q <= cfg_period_i;
            end
            if (!counting || ref_pulse || ovf || (apply && cfg_clr_i)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en_q) state_d = ST_RUN;
            ST_RUN:  if (ovf && !ref_pulse) state_d = ST_WARN;
            ST_WARN: begin
                if (ref_pulse) begin
                    state_d = ST_RUN;
                end else if (ovf) begin
                    state_d = ST_TRIP;
                end
            end
            ST_TRIP: state_d = ST_TRIP;
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            irq_q     <= (state_d == ST_WARN);
            rst_req_q <= (state_d == ST_TRIP);
        end
    end

    assign ack_tgl_o = req_prev_q;
    assign irq_o     = irq_q;
    assign rst_req_o = rst_req_q;

    assert_trip_sticky_R7: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        rst_req_q |=> rst_req_q);

    assert_trip_after_warn_R7: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        $rose(rst_req_q) |-> $past(irq_q));

    assert_refresh_clears_irq_R6: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        (ref_pulse && irq_q) |=> !irq_q);

    assert_irq_needs_enable_R5: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        irq_q |-> en_q);
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int PRESCALE_W = 20,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk_i,
    input  logic              osc_clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o,
    output logic              rst_req_o
);
    logic                req_tgl, ref_tgl, req_sync, ref_sync;
    logic                ack_tgl, ack_sync, irq_sync;
    logic                cfg_en, cfg_clr;
    logic [PERIOD_W-1:0] cfg_period;
    logic                irq_w;

    wdt2_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .irq_sync_i   (irq_sync),
        .ack_sync_i   (ack_sync),
        .req_tgl_o    (req_tgl),
        .ref_tgl_o    (ref_tgl),
        .cfg_en_o     (cfg_en),
        .cfg_clr_o    (cfg_clr),
        .cfg_period_o (cfg_period)
    );

    wdt2_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_to_osc (
        .clk_i  (osc_clk_i),
        .rst_ni (rst_ni),
        .d_i    ({req_tgl, ref_tgl}),
        .q_o    ({req_sync, ref_sync})
    );

    wdt2_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_to_bus (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({ack_tgl, irq_w}),
        .q_o    ({ack_sync, irq_sync})
    );

    wdt2_core #(.PRESCALE_W(PRESCALE_W)) u_core (
        .osc_clk_i    (osc_clk_i),
        .rst_ni       (rst_ni),
        .req_sync_i   (req_sync),
        .ref_sync_i   (ref_sync),
        .cfg_en_i     (cfg_en),
        .cfg_clr_i    (cfg_clr),
        .cfg_period_i (cfg_period),
        .ack_tgl_o    (ack_tgl),
        .irq_o        (irq_w),
        .rst_req_o    (rst_req_o)
    );

    assign irq_o = irq_w;
endmodule

// File: tb/wdt2_top_test.sv
`timescale 1ns/1ps
module wdt2_top_test;
    localparam int PW = 3;
    localparam int NV = 7;
    localparam int P  = (NV + 1) << PW;

    logic        clk = 1'b0;
    logic        osc = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req;

    int checks = 0;
    int errors = 0;

    wdt2_top #(.ADDR_W(4), .PRESCALE_W(PW)) uut (
        .clk_i(clk), .osc_clk_i(osc), .rst_ni(rst_n), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .rst_req_o(rst_req)
    );

    always #5 clk = ~clk;
    always #8 osc = ~osc;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        bus_read(4'h0, v);
        while (v[1]) bus_read(4'h0, v);
    endtask

    task automatic wait_osc(input int n);
        repeat (n) @(posedge osc);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(posedge osc);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_wdt();
        bus_write(4'h4, NV << 20);
        wait_idle();
        bus_write(4'h0, 32'h1);
        wait_idle();
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            bus_read(4'(i * 4), v);
            check("R1 reg", v, 32'h0);
        end
        check("R1 irq_o", {31'h0, irq}, 32'h0);
        check("R1 rst_req_o", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_period_and_busy();
        logic [31:0] v;
        do_reset();
        bus_write(4'h4, 32'hABCDE123);
        bus_read(4'h0, v);
        check("R4 busy set", {31'h0, v[1]}, 32'h1);
        bus_write(4'h4, 32'h12300000);
        wait_idle();
        bus_read(4'h4, v);
        check("R2 period masked / R4 busy write ignored", v, 32'hABC00000);
        bus_read(4'h8, v);
        check("R8 elapsed reads zero", v, 32'h0);
        bus_write(4'h0, 32'h1);
        wait_idle();
        bus_write(4'h0, 32'h0);
        wait_idle();
        bus_read(4'h0, v);
        check("R3 enable sticky", v, 32'h1);
    endtask

    task automatic t_irq_and_trip();
        logic [31:0] v;
        do_reset();
        start_wdt();
        wait_osc(P - 8);
        check("R5 irq low before period", {31'h0, irq}, 32'h0);
        wait_osc(14);
        check("R5 irq high after period", {31'h0, irq}, 32'h1);
        bus_read(4'hC, v);
        check("R5 irq readback", v, 32'h1);
        check("R7 no reset yet", {31'h0, rst_req}, 32'h0);
        wait_osc(P - 14);
        check("R7 reset low before second period", {31'h0, rst_req}, 32'h0);
        wait_osc(14);
        check("R7 reset high after second period", {31'h0, rst_req}, 32'h1);
        check("R7 irq dropped in trip", {31'h0, irq}, 32'h0);
        bus_write(4'hC, 32'h1);
        wait_osc(20);
        check("R7 reset survives refresh", {31'h0, rst_req}, 32'h1);
        do_reset();
        check("R10 reset clears rst_req_o", {31'h0, rst_req}, 32'h0);
        bus_read(4'h0, v);
        check("R10 enable cleared", v, 32'h0);
        bus_read(4'h4, v);
        check("R10 period cleared", v, 32'h0);
    endtask

    task automatic t_refresh();
        do_reset();
        start_wdt();
        wait_osc(P / 2);
        bus_write(4'hC, 32'h1);
        wait_osc(P - 8);
        check("R6 no irq a period after refresh start", {31'h0, irq}, 32'h0);
        wait_osc(16);
        check("R6 irq after full period", {31'h0, irq}, 32'h1);
        bus_write(4'hC, 32'h1);
        wait_osc(8);
        check("R6 refresh clears irq", {31'h0, irq}, 32'h0);
        check("R6 no reset after refresh", {31'h0, rst_req}, 32'h0);
    endtask

    task automatic t_elapsed_clear();
        do_reset();
        start_wdt();
        wait_osc(P / 2);
        bus_write(4'h8, 32'h0);
        wait_idle();
        wait_osc(P - 8);
        check("R8 count restarted", {31'h0, irq}, 32'h0);
        wait_osc(14);
        check("R8 irq after restarted period", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_refresh_zero();
        do_reset();
        start_wdt();
        wait_osc(P / 2);
        bus_write(4'hC, 32'hFFFFFFFE);
        wait_osc(P / 2 + 6);
        check("R9 bit0 zero write ignored", {31'h0, irq}, 32'h1);
    endtask

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_period_and_busy();
        t_irq_and_trip();
        t_refresh();
        t_elapsed_clear();
        t_refresh_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule